// File: doc/BRIEF.md
# Harmonic-Tracking Angle Source

This block produces the 12-bit rotation angle consumed by a vector rotator. The angle comes from one of two places. The first is a wrap-around up/down step counter that advances one count for each rising edge of a step pulse. Because one wrap of the counter is one electrical revolution, a step rate of 4096·n·f locks the rotating frame to harmonic n of a fundamental at frequency f. The second is a mechanical position word from a position sensor. It is scaled to an electrical angle by shifting it left by a selectable number of places, for motors with a power-of-two pole-pair count.

The chosen angle is offered to the downstream converter through a strobe/busy handshake. A new value is launched only when it differs from the last value offered and the converter's busy line is low. The strobe pulse has a fixed high width and a guaranteed low gap before the next pulse, and both are set in clock cycles.

Top module: `harm_angle_gen`

## Requirements
- R1: After reset the angle output is 0, the strobe is low and the step counter holds 0.
- R2: With dir_up high, each rising edge of step_in raises the counter by one modulo 4096, so 4095 is followed by 0 and 4096 steps return to the starting value.
- R3: With dir_up low, each rising edge of step_in lowers the counter by one modulo 4096, so 0 is followed by 4095.
- R4: The counter moves once per rising edge of step_in, however long the input stays high. The input must stay high for at least 2 clocks and low for at least 2 clocks.
- R5: With src_pos high, the candidate angle is the position word (16 bits) shifted left by pp_shift places (0 to 3). The upper 12 bits of the 16-bit result are kept, which is bits [15-pp_shift : 4-pp_shift] of the word, and bits shifted out at the top are discarded.
- R6: With src_pos low, the candidate angle is the step counter value.
- R7: A strobe is launched only when the candidate differs from angle_out and busy_in is low. angle_out takes the candidate on the same clock edge at which the strobe rises.
- R8: Each strobe pulse is high for exactly STB_HIGH clocks (default 4).
- R9: After the strobe falls it stays low for at least STB_GAP clocks (default 3) before it rises again.
- R10: angle_out changes only on the edge where the strobe rises, and it holds steady while the strobe is high.
- R11: While busy_in is high no strobe starts. A change held back by busy is offered once busy_in returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step pulse train, asynchronous; counted on rising edges |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| pos_word | input | 16 | Mechanical position word from the sensor |
| pp_shift | input | 2 | Number of left-shift places (log2 of pole pairs) |
| src_pos | input | 1 | 1 = scaled position is the source, 0 = step counter |
| busy_in | input | 1 | Converter busy; no launch while high |
| angle_out | output | 12 | Angle offered to the converter |
| strobe_out | output | 1 | Load strobe, active high |

## Verification
The assertions assume that step_in obeys the minimum high and low times and that dir_up is stable around each step edge. Under those conditions the synchronised counter moves by at most one count per clock. They also assume that busy_in changes only between clock edges, so that the busy value seen at the launch edge is the one checked. The stimulus drives every input just after a rising clock edge. It holds each step level for several clocks and changes direction only while step_in is low.

// File: rtl/harm_angle_pkg.sv
package harm_angle_pkg;

    localparam int unsigned DEF_ANG_W    = 12;
    localparam int unsigned DEF_POS_W    = 16;
    localparam int unsigned DEF_SHIFT_W  = 2;
    localparam int unsigned DEF_SYNC_N   = 2;
    localparam int unsigned DEF_STB_HIGH = 4;
    localparam int unsigned DEF_STB_GAP  = 3;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_HIGH = 2'd1,
        LS_GAP  = 2'd2
    } launch_state_e;

    typedef struct packed {
        logic edge_seen;
        logic go_up;
    } step_evt_t;

endpackage

// File: rtl/hat_step_counter.sv
module hat_step_counter
    import harm_angle_pkg::*;
#(
    parameter int unsigned ANG_W  = DEF_ANG_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_in,
    input  logic             dir_up,
    output logic [ANG_W-1:0] count_o
);
    localparam int unsigned LAST = SYNC_N - 1;

    logic [SYNC_N-1:0] step_sync;
    logic [SYNC_N-1:0] dir_sync;
    logic              step_prev;
    step_evt_t         evt;
    logic [ANG_W-1:0]  count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_sync <= '0;
            dir_sync  <= '0;
            step_prev <= 1'b0;
        end else begin
            step_sync <= {step_sync[SYNC_N-2:0], step_in};
            dir_sync  <= {dir_sync[SYNC_N-2:0], dir_up};
            step_prev <= step_sync[LAST];
        end
    end

    always_comb begin
        evt.edge_seen = step_sync[LAST] & ~step_prev;
        evt.go_up     = dir_sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (evt.edge_seen) begin
            if (evt.go_up) count_q <= count_q + 1'b1;
            else           count_q <= count_q - 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/hat_pole_scaler.sv
module hat_pole_scaler
    import harm_angle_pkg::*;
#(
    parameter int unsigned ANG_W   = DEF_ANG_W,
    parameter int unsigned POS_W   = DEF_POS_W,
    parameter int unsigned SHIFT_W = DEF_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [POS_W-1:0]   pos_word,
    input  logic [SHIFT_W-1:0] pp_shift,
    output logic [ANG_W-1:0]   angle_o
);
    localparam int unsigned N_SHIFT = 1 << SHIFT_W;

    logic [ANG_W-1:0] slice [N_SHIFT];
    logic [ANG_W-1:0] angle_q;

    generate
        for (genvar k = 0; k < N_SHIFT; k++) begin : g_slice
            assign slice[k] = pos_word[POS_W-1-k -: ANG_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) angle_q <= '0;
        else     angle_q <= slice[pp_shift];
    end

    assign angle_o = angle_q;

endmodule

// File: rtl/hat_launcher.sv
module hat_launcher
    import harm_angle_pkg::*;
#(
    parameter int unsigned ANG_W    = DEF_ANG_W,
    parameter int unsigned STB_HIGH = DEF_STB_HIGH,
    parameter int unsigned STB_GAP  = DEF_STB_GAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] cand_i,
    input  logic             busy_in,
    output logic [ANG_W-1:0] angle_o,
    output logic             strobe_o
);
    localparam int unsigned T_MAX = (STB_HIGH > STB_GAP) ? STB_HIGH : STB_GAP;
    localparam int unsigned TMR_W = $clog2(T_MAX + 1);
    localparam logic [TMR_W-1:0] HIGH_LOAD = TMR_W'(STB_HIGH - 1);
    localparam logic [TMR_W-1:0] GAP_LOAD  = TMR_W'(STB_GAP - 1);

    launch_state_e    state;
    logic [TMR_W-1:0] tmr;
    logic [ANG_W-1:0] angle_q;
    logic             strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_IDLE;
            tmr      <= '0;
            angle_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            unique case (state)
                LS_IDLE: begin
                    if ((cand_i != angle_q) && !busy_in) begin
                        angle_q  <= cand_i;
                        strobe_q <= 1'b1;
                        tmr      <= HIGH_LOAD;
                        state    <= LS_HIGH;
                    end
                end
                LS_HIGH: begin
                    if (tmr == '0) begin
                        strobe_q <= 1'b0;
                        tmr      <= GAP_LOAD;
                        state    <= LS_GAP;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                LS_GAP: begin
                    if (tmr == '0) state <= LS_IDLE;
                    else           tmr   <= tmr - 1'b1;
                end
                default: state <= LS_IDLE;
            endcase
        end
    end

    assign angle_o  = angle_q;
    assign strobe_o = strobe_q;

endmodule

// File: rtl/harm_angle_gen.sv
module harm_angle_gen
    import harm_angle_pkg::*;
#(
    parameter int unsigned ANG_W    = DEF_ANG_W,
    parameter int unsigned POS_W    = DEF_POS_W,
    parameter int unsigned SHIFT_W  = DEF_SHIFT_W,
    parameter int unsigned SYNC_N   = DEF_SYNC_N,
    parameter int unsigned STB_HIGH = DEF_STB_HIGH,
    parameter int unsigned STB_GAP  = DEF_STB_GAP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_in,
    input  logic               dir_up,
    input  logic [POS_W-1:0]   pos_word,
    input  logic [SHIFT_W-1:0] pp_shift,
    input  logic               src_pos,
    input  logic               busy_in,
    output logic [ANG_W-1:0]   angle_out,
    output logic               strobe_out
);
    logic [ANG_W-1:0] count_w;
    logic [ANG_W-1:0] scaled_w;
    logic [ANG_W-1:0] cand_w;

    hat_step_counter #(.ANG_W(ANG_W), .SYNC_N(SYNC_N)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step_in (step_in),
        .dir_up  (dir_up),
        .count_o (count_w)
    );

    hat_pole_scaler #(.ANG_W(ANG_W), .POS_W(POS_W), .SHIFT_W(SHIFT_W)) u_scale (
        .clk      (clk),
        .rst      (rst),
        .pos_word (pos_word),
        .pp_shift (pp_shift),
        .angle_o  (scaled_w)
    );

    assign cand_w = src_pos ? scaled_w : count_w;

    hat_launcher #(.ANG_W(ANG_W), .STB_HIGH(STB_HIGH), .STB_GAP(STB_GAP)) u_launch (
        .clk      (clk),
        .rst      (rst),
        .cand_i   (cand_w),
        .busy_in  (busy_in),
        .angle_o  (angle_out),
        .strobe_o (strobe_out)
    );

endmodule

// File: rtl/harm_angle_chk.sv
module harm_angle_chk #(
    parameter int unsigned ANG_W    = 12,
    parameter int unsigned STB_HIGH = 4,
    parameter int unsigned STB_GAP  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_in,
    input logic             strobe_out,
    input logic [ANG_W-1:0] angle_out,
    input logic [ANG_W-1:0] count_w
);
    logic [15:0]      hi_cnt;
    logic [15:0]      lo_cnt;
    logic [ANG_W-1:0] cnt_prev;
    logic [ANG_W-1:0] cnt_diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            lo_cnt   <= 16'(STB_GAP);
            cnt_prev <= '0;
        end else begin
            cnt_prev <= count_w;
            if (strobe_out) begin
                hi_cnt <= hi_cnt + 16'd1;
                lo_cnt <= '0;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
            end
        end
    end

    assign cnt_diff = count_w - cnt_prev;

    // R2, R3, R4: the counter moves by at most one count per clock
    p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_diff == '0) || (cnt_diff == ANG_W'(1)) || (cnt_diff == '1));

    p_strobe_width_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_out) |-> (hi_cnt == 16'(STB_HIGH)));

    p_strobe_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_out) |-> (lo_cnt >= 16'(STB_GAP)));

    p_hold_while_high_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe_out && $past(strobe_out)) |-> $stable(angle_out));

    p_change_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(angle_out) |-> $rose(strobe_out));

    p_no_launch_busy_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_out) |-> !$past(busy_in));

endmodule

bind harm_angle_gen harm_angle_chk #(
    .ANG_W    (ANG_W),
    .STB_HIGH (STB_HIGH),
    .STB_GAP  (STB_GAP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_in    (busy_in),
    .strobe_out (strobe_out),
    .angle_out  (angle_out),
    .count_w    (count_w)
);

// File: tb/harm_angle_gen_tb.sv
module harm_angle_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_in = 1'b0;
    logic        dir_up = 1'b1;
    logic [15:0] pos_word = '0;
    logic [1:0]  pp_shift = '0;
    logic        src_pos = 1'b0;
    logic        busy_in = 1'b0;
    logic [11:0] angle_out;
    logic        strobe_out;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_cnt  = 0;
    int rises    = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    harm_angle_gen u_dut (
        .clk(clk), .rst(rst), .step_in(step_in), .dir_up(dir_up),
        .pos_word(pos_word), .pp_shift(pp_shift), .src_pos(src_pos),
        .busy_in(busy_in), .angle_out(angle_out), .strobe_out(strobe_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // one step: high 4 clocks, low 8 clocks, counter and launch settle inside
    task automatic step(input bit up);
        dir_up = up;
        cyc(1);
        step_in = 1'b1;
        cyc(4);
        step_in = 1'b0;
        cyc(8);
        exp_cnt = up ? ((exp_cnt + 1) & 12'hFFF) : ((exp_cnt + 4095) & 12'hFFF);
    endtask

    // strobe monitor on the falling edge
    int hi_run = 0;
    int lo_run = 100;
    logic prev_stb = 1'b0;
    logic prev_busy = 1'b0;
    logic [11:0] prev_ang = '0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (strobe_out && !prev_stb) begin
                rises++;
                check("R9 gap before strobe", (lo_run >= 3) ? 1 : 0, 1);
                check("R11 busy low at launch", int'(prev_busy), 0);
            end
            if (!strobe_out && prev_stb)
                check("R8 strobe width", hi_run, 4);
            if (strobe_out && prev_stb)
                check("R10 angle held while strobe high", int'(angle_out), int'(prev_ang));
            if (!strobe_out && !prev_stb && angle_out != prev_ang)
                check("R10 angle changed without strobe", int'(angle_out), int'(prev_ang));
            if (strobe_out) begin hi_run++; lo_run = 0; end
            else            begin lo_run++; hi_run = 0; end
        end
        prev_stb  = strobe_out;
        prev_busy = busy_in;
        prev_ang  = angle_out;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int r0;
        cyc(3);
        check("R1 angle after reset", int'(angle_out), 0);
        check("R1 strobe after reset", int'(strobe_out), 0);
        rst = 1'b0;
        cyc(10);
        check("R1 counter idle at 0", int'(angle_out), 0);

        // R2: full up wrap, every value checked, 4095 -> 0 included
        for (int i = 0; i < 4096; i++) begin
            step(1'b1);
            check("R2 count up", int'(angle_out), exp_cnt);
        end
        check("R2 full wrap returns to start", int'(angle_out), 0);

        // R3: down through zero
        for (int i = 0; i < 40; i++) begin
            step(1'b0);
            check("R3 count down", int'(angle_out), exp_cnt);
        end

        // R4: level held high counts only once
        dir_up = 1'b1;
        cyc(1);
        step_in = 1'b1;
        cyc(40);
        step_in = 1'b0;
        cyc(10);
        exp_cnt = (exp_cnt + 1) & 12'hFFF;
        check("R4 single count per edge", int'(angle_out), exp_cnt);

        // R5: scaled position, all shifts, several words
        src_pos = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 16; i++) begin
                int w;
                w = ((i * 16'h3A5B) + 16'h1234 + (s << 9)) & 16'hFFFF;
                pos_word = 16'(w);
                pp_shift = 2'(s);
                cyc(14);
                check("R5 scaled position", int'(angle_out), ((w << s) >> 4) & 12'hFFF);
            end
        end

        // R6: back to counter source
        src_pos = 1'b0;
        cyc(14);
        check("R6 counter source", int'(angle_out), exp_cnt);

        // R7: no change, no strobe
        r0 = rises;
        cyc(30);
        check("R7 no strobe without change", rises - r0, 0);

        // R11: busy holds a pending change back
        busy_in = 1'b1;
        r0 = rises;
        step(1'b1);
        cyc(20);
        check("R11 no strobe while busy", rises - r0, 0);
        check("R11 angle held while busy", int'(angle_out), (exp_cnt + 4095) & 12'hFFF);
        busy_in = 1'b0;
        cyc(12);
        check("R11 pending change offered", int'(angle_out), exp_cnt);
        check("R7 exactly one launch", rises - r0, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule